// File: doc/BRIEF.md
# Serial Receive Queue with Fill Trigger and Idle Timeout

This block holds received characters for a 16550-style serial port until software reads them. The queue has 16 entries. Each entry stores a data byte together with its break, framing-error and parity-error flags, and those flags come out alongside the byte once it reaches the head. The deserializer pulses `rx_push` once for each completed character. A read of the data register pulses `rd_pop`. A write to the queue control register arrives as `ctl_wr` with the byte on `ctl_data`.

Bit 0 of the control byte selects 16-entry mode. When that bit is 0 the block acts as a single-byte holding register. Writing bit 1 empties the queue, but only when bit 0 is also 1 in the same write. Bits 7..6 set the fill level at which `trig_hit` is raised. A free-running character-time pulse, `char_tick`, drives an idle counter. That counter raises `timeout` when characters sit in the queue below the attention of the trigger logic. The interrupt logic around the block combines `trig_hit`, `timeout` and `overrun` into its own reporting.

Top module: `uart_rxq`

## Requirements
- R1: After reset the queue is empty, 16-entry mode is off, the trigger selection is 00, and `data_ready`, `overrun`, `trig_hit` and `timeout` are 0. `head_data` and the three head flags are 0.
- R2: A control write whose bit 0 differs from the current mode switches the mode to that bit. The same write empties the queue and clears `overrun` and `timeout`. In 16-entry mode, 16 characters are held without loss.
- R3: A control write with bits 1 and 0 both set empties the queue and clears `overrun` and `timeout` on the next edge, overriding any push or read in that cycle. A write with bit 1 set and bit 0 equal to 0 leaves the queue untouched when the mode does not change.
- R4: Characters leave in arrival order. `head_data`, `head_brk`, `head_fe` and `head_pe` show the oldest stored character and its own flags, and they read 0 while the queue is empty.
- R5: `data_ready` is 1 exactly while at least one character is stored.
- R6: `trig_hit` is 1 while the fill count is at least the selected level. In 16-entry mode, bits 7..6 give the level: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. In single-byte mode the level is 1.
- R7: When `rx_push` arrives with no free entry and no accepted read in the same cycle, the new character is discarded, stored contents are kept, and `overrun` is set. `overrun` stays set until the next accepted read or an empty-the-queue write.
- R8: `rx_push` and `rd_pop` together on a full queue both take effect with no overrun. `rd_pop` on an empty queue has no effect.
- R9: In single-byte mode the capacity is one character. A second character arriving before a read is an overrun.
- R10: In 16-entry mode `timeout` becomes 1 on the edge of the fourth `char_tick` counted while the queue is non-empty with no `rx_push` and no `rd_pop`. The count restarts on any `rx_push` or `rd_pop`, or while the queue is empty. `timeout` clears on the next accepted read and is never raised in single-byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Queue control register write strobe |
| ctl_data | input | 8 | Control byte: bit 0 mode, bit 1 empty, bits 7..6 trigger |
| rx_push | input | 1 | Character completed by the deserializer |
| rx_data | input | 8 | Received data byte |
| rx_pe | input | 1 | Parity error of the received character |
| rx_fe | input | 1 | Framing error of the received character |
| rx_brk | input | 1 | Break detected on the received character |
| rd_pop | input | 1 | Data register read strobe |
| char_tick | input | 1 | One pulse per character time |
| head_data | output | 8 | Oldest stored byte |
| head_pe | output | 1 | Parity error of the oldest byte |
| head_fe | output | 1 | Framing error of the oldest byte |
| head_brk | output | 1 | Break flag of the oldest byte |
| data_ready | output | 1 | At least one character stored |
| overrun | output | 1 | A character was lost to a full queue |
| trig_hit | output | 1 | Fill count at or above the trigger level |
| timeout | output | 1 | Stored data left unread for four character times |

## Verification
A wrong read or write pointer appears at the head outputs on the first read after the fault. The byte or its flags no longer match the arrival order, and the per-cycle comparison against the behavioural queue catches it at the next falling edge. A miscount of the fill level shifts `trig_hit` and `data_ready` and shows the wrong moment at which `overrun` appears, again within one cycle of the faulty edge. An idle counter that restarts or saturates wrongly moves the rise of `timeout` by at least one tick. The check against the model's tick count detects this on the edge where the flag should have changed.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int RXQ_DATA_W = 8;

  typedef struct packed {
    logic                  brk;
    logic                  fe;
    logic                  pe;
    logic [RXQ_DATA_W-1:0] data;
  } rxq_entry_t;

  typedef enum logic [1:0] {
    TRIG_ONE      = 2'b00,
    TRIG_QUARTER  = 2'b01,
    TRIG_HALF     = 2'b10,
    TRIG_NEARFULL = 2'b11
  } trig_sel_e;

  function automatic int unsigned trig_level(input trig_sel_e sel);
    case (sel)
      TRIG_ONE:      trig_level = 1;
      TRIG_QUARTER:  trig_level = 4;
      TRIG_HALF:     trig_level = 8;
      default:       trig_level = 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  rxq_entry_t       wdata,
  output rxq_entry_t       head,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rxq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    ptr_inc = (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = ptr_inc(wptr_q);
      if (pop)  rptr_d = ptr_inc(rptr_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage array: data path only, written under its own enable
  always_ff @(posedge clk) begin
    if (push && !clr) mem[wptr_q] <= wdata;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/uart_rxq_level.sv
module uart_rxq_level
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en,
  input  trig_sel_e        trig_sel,
  input  logic [CNT_W-1:0] count,
  output logic             trig_hit,
  output logic             at_cap
);
  localparam logic [CNT_W-1:0] CAP_DEEP = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] level;
  logic [CNT_W-1:0] cap;

  always_comb begin
    if (fifo_en) begin
      level = CNT_W'(trig_level(trig_sel));
      cap   = CAP_DEEP;
    end else begin
      level = CAP_ONE;
      cap   = CAP_ONE;
    end
    trig_hit = (count >= level);
    at_cap   = (count >= cap);
  end
endmodule

// File: rtl/uart_rxq_idle.sv
module uart_rxq_idle #(
  parameter int TO_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fifo_en,
  input  logic nonempty,
  input  logic rx_push,
  input  logic rd_pop,
  input  logic pop_ok,
  input  logic char_tick,
  output logic timeout
);
  localparam int IDLE_W = $clog2(TO_TICKS + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(TO_TICKS);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TO_TICKS - 1);

  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              to_q, to_d;
  logic              quiet;

  assign quiet = nonempty && !rx_push && !rd_pop;

  always_comb begin
    idle_d = idle_q;
    to_d   = to_q;
    if (clr) begin
      idle_d = '0;
      to_d   = 1'b0;
    end else begin
      if (!quiet) begin
        idle_d = '0;
      end else if (char_tick && (idle_q != IDLE_MAX)) begin
        idle_d = idle_q + 1'b1;
      end
      if (pop_ok) begin
        to_d = 1'b0;
      end else if (fifo_en && quiet && char_tick && (idle_q == IDLE_LAST)) begin
        to_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      to_q   <= 1'b0;
    end else begin
      idle_q <= idle_d;
      to_q   <= to_d;
    end
  end

  assign timeout = to_q;
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  input  logic       rx_push,
  input  logic [7:0] rx_data,
  input  logic       rx_pe,
  input  logic       rx_fe,
  input  logic       rx_brk,
  input  logic       rd_pop,
  input  logic       char_tick,
  output logic [7:0] head_data,
  output logic       head_pe,
  output logic       head_fe,
  output logic       head_brk,
  output logic       data_ready,
  output logic       overrun,
  output logic       trig_hit,
  output logic       timeout
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             fifo_en_q, fifo_en_d;
  trig_sel_e        trig_sel_q, trig_sel_d;
  logic             ovr_q, ovr_d;
  logic             clr;
  logic             pop_ok, push_ok, drop;
  logic             at_cap;
  logic [CNT_W-1:0] count;
  logic             nonempty;
  rxq_entry_t       wdata, head;

  assign nonempty = (count != '0);
  assign clr      = ctl_wr && ((ctl_data[0] && ctl_data[1]) || (ctl_data[0] != fifo_en_q));
  assign pop_ok   = rd_pop && nonempty;
  assign push_ok  = rx_push && (!at_cap || pop_ok);
  assign drop     = rx_push && at_cap && !pop_ok;

  assign wdata = '{brk: rx_brk, fe: rx_fe, pe: rx_pe, data: rx_data};

  always_comb begin
    fifo_en_d  = fifo_en_q;
    trig_sel_d = trig_sel_q;
    ovr_d      = ovr_q;
    if (ctl_wr) begin
      fifo_en_d  = ctl_data[0];
      trig_sel_d = trig_sel_e'(ctl_data[7:6]);
    end
    if (clr) begin
      ovr_d = 1'b0;
    end else if (drop) begin
      ovr_d = 1'b1;
    end else if (pop_ok) begin
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q  <= 1'b0;
      trig_sel_q <= TRIG_ONE;
      ovr_q      <= 1'b0;
    end else begin
      fifo_en_q  <= fifo_en_d;
      trig_sel_q <= trig_sel_d;
      ovr_q      <= ovr_d;
    end
  end

  uart_rxq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .push  (push_ok),
    .pop   (pop_ok),
    .wdata (wdata),
    .head  (head),
    .count (count)
  );

  uart_rxq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .fifo_en  (fifo_en_q),
    .trig_sel (trig_sel_q),
    .count    (count),
    .trig_hit (trig_hit),
    .at_cap   (at_cap)
  );

  uart_rxq_idle #(.TO_TICKS(TO_TICKS)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .fifo_en   (fifo_en_q),
    .nonempty  (nonempty),
    .rx_push   (rx_push),
    .rd_pop    (rd_pop),
    .pop_ok    (pop_ok),
    .char_tick (char_tick),
    .timeout   (timeout)
  );

  assign data_ready = nonempty;
  assign overrun    = ovr_q;
  assign head_data  = nonempty ? head.data : '0;
  assign head_pe    = nonempty && head.pe;
  assign head_fe    = nonempty && head.fe;
  assign head_brk   = nonempty && head.brk;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_data,
  input logic       rx_push,
  input logic       rd_pop,
  input logic [7:0] head_data,
  input logic       head_pe,
  input logic       head_fe,
  input logic       head_brk,
  input logic       data_ready,
  input logic       overrun,
  input logic       trig_hit,
  input logic       timeout
);
  AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> (head_data == 8'h00 && !head_pe && !head_fe && !head_brk)); // R4

  AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_ready); // R6

  AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> data_ready); // R10

  AST_OVERRUN_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(rx_push) && data_ready)); // R7

  AST_READ_DROPS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && data_ready) |=> !timeout); // R10

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_data[0] && ctl_data[1]) |=> (!data_ready && !overrun && !timeout)); // R3
endmodule

bind uart_rxq uart_rxq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_data   (ctl_data),
  .rx_push    (rx_push),
  .rd_pop     (rd_pop),
  .head_data  (head_data),
  .head_pe    (head_pe),
  .head_fe    (head_fe),
  .head_brk   (head_brk),
  .data_ready (data_ready),
  .overrun    (overrun),
  .trig_hit   (trig_hit),
  .timeout    (timeout)
);

// File: tb/uart_rxq_bench.sv
module uart_rxq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = '0;
  logic       rx_push = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_pe = 1'b0, rx_fe = 1'b0, rx_brk = 1'b0;
  logic       rd_pop = 1'b0;
  logic       char_tick = 1'b0;
  logic [7:0] head_data;
  logic       head_pe, head_fe, head_brk;
  logic       data_ready, overrun, trig_hit, timeout;

  always #2.5 clk = ~clk;

  uart_rxq u_uart_rxq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .rx_push(rx_push), .rx_data(rx_data), .rx_pe(rx_pe), .rx_fe(rx_fe),
    .rx_brk(rx_brk), .rd_pop(rd_pop), .char_tick(char_tick),
    .head_data(head_data), .head_pe(head_pe), .head_fe(head_fe),
    .head_brk(head_brk), .data_ready(data_ready), .overrun(overrun),
    .trig_hit(trig_hit), .timeout(timeout)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural reference: entries packed as {brk, fe, pe, data}
  logic [10:0] q[$];
  bit m_en = 0;
  int m_sel = 0;
  bit m_ovr = 0;
  bit m_to = 0;
  int m_idle = 0;

  function automatic int lvl();
    if (!m_en) return 1;
    case (m_sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      int sz, cap;
      bit clr, pop, full;
      sz = q.size();
      cap = m_en ? 16 : 1;
      clr = ctl_wr && ((ctl_data[0] && ctl_data[1]) || (ctl_data[0] != m_en));
      pop = rd_pop && sz > 0;
      full = sz >= cap;
      if (clr) begin
        q.delete(); m_ovr = 0; m_to = 0; m_idle = 0;
      end else begin
        if (rx_push || rd_pop || sz == 0) m_idle = 0;
        else if (char_tick && m_idle < 4) begin
          m_idle++;
          if (m_idle == 4 && m_en) m_to = 1;
        end
        if (pop) begin
          void'(q.pop_front()); m_ovr = 0; m_to = 0;
        end
        if (rx_push) begin
          if (!full || pop) q.push_back({rx_brk, rx_fe, rx_pe, rx_data});
          else m_ovr = 1;
        end
      end
      if (ctl_wr) begin
        m_en = ctl_data[0];
        m_sel = int'(ctl_data[7:6]);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [10:0] exp_head;
      exp_head = (q.size() > 0) ? q[0] : 11'h0;
      chk({head_brk, head_fe, head_pe, head_data} == exp_head, "R4 head",
          int'({head_brk, head_fe, head_pe, head_data}), int'(exp_head));
      chk(data_ready == (q.size() > 0), "R5 data_ready", data_ready, q.size() > 0);
      chk(trig_hit == (q.size() >= lvl()), "R6 trig_hit", trig_hit, q.size() >= lvl());
      chk(overrun == m_ovr, "R7 overrun", overrun, m_ovr);
      chk(timeout == m_to, "R10 timeout", timeout, m_to);
    end
  end

  task automatic step(input bit p, input logic [10:0] d, input bit r, input bit t,
                      input bit w, input logic [7:0] c);
    rx_push = p; {rx_brk, rx_fe, rx_pe, rx_data} = d; rd_pop = r;
    char_tick = t; ctl_wr = w; ctl_data = c;
    @(negedge clk);
    rx_push = 0; rd_pop = 0; char_tick = 0; ctl_wr = 0;
  endtask

  task automatic push(input logic [10:0] d); step(1, d, 0, 0, 0, 8'h00); endtask
  task automatic pop();  step(0, 0, 1, 0, 0, 8'h00); endtask
  task automatic tick(); step(0, 0, 0, 1, 0, 8'h00); endtask
  task automatic ctl(input logic [7:0] c); step(0, 0, 0, 0, 1, c); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!data_ready && !overrun && !trig_hit && !timeout && head_data == 0,
        "R1 reset state", {data_ready, overrun, trig_hit, timeout}, 0);

    // single-byte mode
    push(11'h1A5);
    push(11'h03C);
    chk(overrun && head_data == 8'hA5, "R9 capacity one", {overrun, head_data}, 9'h1A5);
    ctl(8'h02);
    chk(data_ready && head_data == 8'hA5, "R3 clear without enable ignored", data_ready, 1);
    pop();
    chk(!overrun && !data_ready, "R7 read clears overrun", overrun, 0);
    pop();
    chk(!data_ready && !overrun, "R8 read on empty ignored", data_ready, 0);
    push(11'h011); tick(); tick(); tick(); tick(); tick();
    chk(!timeout, "R10 no timeout in single mode", timeout, 0);

    // switch to 16-entry mode, trigger 4
    ctl(8'h41);
    chk(!data_ready, "R2 mode change empties", data_ready, 0);
    for (int i = 0; i < 4; i++) begin
      push(11'(i * 37 + 16'h200));
      chk(trig_hit == (i >= 3), "R6 trigger level 4", trig_hit, i >= 3);
    end
    ctl(8'hC1);
    for (int i = 4; i < 16; i++) push(11'(i * 53));
    chk(!overrun && trig_hit, "R2 sixteen held", overrun, 0);
    push(11'h7FF);
    chk(overrun && head_data == 8'd37 * 0 + 8'h00, "R7 drop keeps head", head_data, 0);
    step(1, 11'h155, 1, 0, 0, 8'h00);
    chk(!overrun, "R8 push and pop on full", overrun, 0);
    ctl(8'h87);
    chk(!data_ready && !overrun, "R3 clear with enable", data_ready, 0);

    // timeout below the trigger
    ctl(8'hC1);
    push(11'h0AA); push(11'h0BB);
    tick(); tick(); tick();
    chk(!timeout, "R10 three ticks not enough", timeout, 0);
    tick();
    chk(timeout, "R10 fourth tick raises", timeout, 1);
    pop();
    chk(!timeout, "R10 read clears", timeout, 0);
    tick(); tick(); push(11'h0CC); tick(); tick(); tick();
    chk(!timeout, "R10 push restarts count", timeout, 0);
    tick();
    chk(timeout, "R10 raised after restart", timeout, 1);

    // mixed traffic against the model
    for (int i = 0; i < 6000; i++) begin
      bit w;
      logic [7:0] c;
      w = ($urandom_range(0, 199) == 0);
      c = 8'($urandom);
      if ($urandom_range(0, 3) != 0) c[0] = 1'b1;
      step($urandom_range(0, 9) < 4, 11'($urandom), $urandom_range(0, 9) < 3,
           $urandom_range(0, 9) < 4, w, c);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule